// File: doc/BRIEF.md
# Chained-Descriptor Word DMA Engine

This block is a single-channel DMA engine that moves 32-bit words between system memory and one peripheral data port. Software places a chain of descriptors in memory and writes one command word holding the first descriptor's address together with a start bit. The engine then works without further help. For each descriptor it reads the control words, moves the blocks it describes, writes a completion code back into the descriptor, pulses an interrupt if asked to, and either follows the next pointer or goes idle.

A descriptor is twelve words long and 32-byte aligned. It can move several equal-sized blocks separated by a fixed gap, and it carries its own direction bit, so one chain can mix reads and writes. A next pointer that loops back makes the chain cyclic, which suits streaming buffers. A stop command parks the engine at the next word boundary, and a start command given while parked resumes from the same point.

Memory is reached through one request/acknowledge port that carries single words, so latency may vary. The peripheral side uses a valid/ready handshake for each word in each direction.

Top module: `lld_dma`

## Requirements
- R1: A command write (`ctl_we`) with bit 3 set and bit 4 clear, issued while idle, takes the descriptor address from bits 31:5 with the low five bits forced to zero. On the following cycle `busy` is 1 and `cur_desc` shows that address.
- R2: Descriptor word offsets: word 0 is the next pointer, word 1 the memory byte address, word 2 the peripheral address (driven on `periph_addr` while the descriptor runs), word 3 the block length in words, word 4 the gap between blocks in words, word 5 the block count, and word 6 the command (bit 1 requests an interrupt, bit 12 selects the direction). Only words 0 to 6 are read.
- R3: With command bit 12 = 1, memory words are read in ascending order and presented on `pout_data`. Once `pout_valid` is high, it and the data stay unchanged until `pout_ready` is seen.
- R4: With command bit 12 = 0, words taken from `pin_data` on `pin_valid`&`pin_ready` are written to memory in arrival order. `pout_valid` and `pin_ready` are never high together.
- R5: Word w of block b is at byte address mem + 4*(b*(len+gap)+w). Gap words are never accessed.
- R6: A descriptor whose length or block count is 0 moves no word, but it still writes its status and raises its interrupt.
- R7: After the last word of a descriptor, the value 1 is written to its word 7 (byte offset 28).
- R8: After that status write, `irq` is high for exactly one cycle if command bit 1 is set. Otherwise `irq` stays low.
- R9: If bit 0 of the next pointer is 1, the engine fetches the descriptor at the next pointer with bit 0 cleared. If bit 0 is 0, it goes idle and `busy` falls.
- R10: A chain whose last pointer leads back to the first keeps running, raises one interrupt per descriptor with bit 1 set, and does not stop on its own.
- R11: A command write with bit 4 set halts the engine before its next data word, with no partial word moved and `busy` kept high. A later start command resumes at the point where it halted.
- R12: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ack` is seen.
- R13: While `rst_n` is low, and afterwards until the first command: `busy`, `irq`, `mem_req`, `pout_valid` and `pin_ready` are 0.
- R14: `cur_desc` holds the address of the descriptor in progress, or of the last one handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Command write strobe |
| ctl_wdata | input | 32 | Command word: address 31:5, stop bit 4, start bit 3 |
| busy | output | 1 | Engine active (including parked) |
| cur_desc | output | 32 | Current descriptor byte address |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request done |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| periph_addr | output | 32 | Peripheral address from descriptor |
| pout_valid | output | 1 | Word for peripheral valid |
| pout_data | output | 32 | Word for peripheral |
| pout_ready | input | 1 | Peripheral accepts word |
| pin_valid | input | 1 | Word from peripheral valid |
| pin_data | input | 32 | Word from peripheral |
| pin_ready | output | 1 | Engine accepts peripheral word |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench targets strided blocks, where an engine that ignores the gap or steps it in bytes writes over sentinel words that should stay untouched. It also targets zero-length descriptors: an engine that moves a word anyway, or that never writes status or interrupts, fails the transfer count or the completion checks. Mixed-direction chains with the interrupt bit set on only the last descriptor catch an engine that interrupts on every descriptor or reuses the first one's direction. A stop in mid-transfer followed by a start catches an engine that keeps moving words, drops one, or restarts the chain from the top. A cyclic chain catches an engine that ends on the back pointer.

// File: rtl/lld_pkg.sv
package lld_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_FETCH, ST_PREP, ST_NEXT,
    ST_MRD, ST_PUT, ST_GET, ST_MWR, ST_STAT, ST_FIN
  } lld_state_t;

  // Descriptor word positions (decoded by software, so fixed)
  localparam int unsigned W_NEXT   = 0;
  localparam int unsigned W_MEM    = 1;
  localparam int unsigned W_PERIPH = 2;
  localparam int unsigned W_LEN    = 3;
  localparam int unsigned W_GAP    = 4;
  localparam int unsigned W_BLOCKS = 5;
  localparam int unsigned W_CMD    = 6;
  localparam int unsigned W_STAT   = 7;
  localparam int unsigned FETCH_WORDS = W_CMD + 1;

  localparam int unsigned CMD_IRQ_BIT = 1;
  localparam int unsigned CMD_DIR_BIT = 12;
  localparam int unsigned CTL_START_BIT = 3;
  localparam int unsigned CTL_STOP_BIT  = 4;
  localparam int unsigned CTL_FIELD_W   = 5;
  localparam int unsigned NEXT_VALID_BIT = 0;
endpackage

// File: rtl/lld_ctrl.sv
module lld_ctrl
  import lld_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  input  logic        idle,
  output logic        go,
  output logic [31:0] go_addr,
  output logic        halted
);
  logic start_cmd, stop_cmd;
  logic halted_d;

  assign stop_cmd  = ctl_we && ctl_wdata[CTL_STOP_BIT];
  assign start_cmd = ctl_we && ctl_wdata[CTL_START_BIT] && !ctl_wdata[CTL_STOP_BIT];
  assign go        = start_cmd && idle;
  assign go_addr   = {ctl_wdata[31:CTL_FIELD_W], {CTL_FIELD_W{1'b0}}};

  always_comb begin
    halted_d = halted;
    if (stop_cmd)       halted_d = 1'b1;
    else if (start_cmd) halted_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted <= 1'b0;
    else        halted <= halted_d;
  end
endmodule

// File: rtl/lld_walker.sv
module lld_walker #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic [31:0]      base,
  input  logic [CNT_W-1:0] len,
  input  logic [CNT_W-1:0] gap,
  input  logic [CNT_W-1:0] blocks,
  output logic [31:0]      addr,
  output logic             done
);
  logic [31:0]      blk_q, blk_d, cur_d, stride;
  logic [CNT_W-1:0] wcnt_q, wcnt_d, bcnt_q, bcnt_d;
  logic             last_word;

  assign stride    = (32'(len) + 32'(gap)) << 2;
  assign last_word = (wcnt_q == len - CNT_W'(1));
  assign done      = (len == '0) || (bcnt_q == blocks);

  always_comb begin
    blk_d  = blk_q;
    cur_d  = addr;
    wcnt_d = wcnt_q;
    bcnt_d = bcnt_q;
    if (init) begin
      blk_d  = base;
      cur_d  = base;
      wcnt_d = '0;
      bcnt_d = '0;
    end else if (step) begin
      if (last_word) begin
        wcnt_d = '0;
        bcnt_d = bcnt_q + CNT_W'(1);
        blk_d  = blk_q + stride;
        cur_d  = blk_q + stride;
      end else begin
        wcnt_d = wcnt_q + CNT_W'(1);
        cur_d  = addr + 32'd4;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      addr   <= '0;
      wcnt_q <= '0;
      bcnt_q <= '0;
    end else if (init || step) begin
      blk_q  <= blk_d;
      addr   <= cur_d;
      wcnt_q <= wcnt_d;
      bcnt_q <= bcnt_d;
    end
  end
endmodule

// File: rtl/lld_seq.sv
module lld_seq
  import lld_pkg::*;
#(
  parameter logic [31:0] STATUS_CODE = 32'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] go_addr,
  input  logic        halted,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        pout_ready,
  input  logic        pin_valid,
  input  logic [31:0] pin_data,
  input  logic [31:0] walk_addr,
  input  logic        walk_done,
  output logic        walk_init,
  output logic        walk_step,
  output logic [31:0] f_mem,
  output logic [31:0] f_len,
  output logic [31:0] f_gap,
  output logic [31:0] f_blocks,
  output logic [31:0] periph_addr,
  output logic        busy,
  output logic [31:0] cur_desc,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        pout_valid,
  output logic [31:0] pout_data,
  output logic        pin_ready,
  output logic        irq
);
  localparam int unsigned FIDX_W = $clog2(FETCH_WORDS);
  localparam logic [FIDX_W-1:0] LAST_FIELD = FIDX_W'(FETCH_WORDS - 1);
  localparam logic [31:0] STAT_OFS = 32'(W_STAT * 4);

  lld_state_t        state_q, state_d;
  logic [31:0]       desc_q, desc_d, hold_q, hold_d;
  logic [FIDX_W-1:0] fidx_q, fidx_d;
  logic              irq_q, irq_d, fld_we;
  logic [31:0]       fld_q [FETCH_WORDS];
  logic [31:0]       nxt, cmd;

  assign nxt         = fld_q[W_NEXT];
  assign cmd         = fld_q[W_CMD];
  assign f_mem       = fld_q[W_MEM];
  assign f_len       = fld_q[W_LEN];
  assign f_gap       = fld_q[W_GAP];
  assign f_blocks    = fld_q[W_BLOCKS];
  assign periph_addr = fld_q[W_PERIPH];
  assign busy        = (state_q != ST_IDLE);
  assign cur_desc    = desc_q;
  assign pout_data   = hold_q;
  assign irq         = irq_q;

  always_comb begin
    state_d    = state_q;
    desc_d     = desc_q;
    fidx_d     = fidx_q;
    hold_d     = hold_q;
    irq_d      = 1'b0;
    fld_we     = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = walk_addr;
    mem_wdata  = hold_q;
    pout_valid = 1'b0;
    pin_ready  = 1'b0;
    walk_init  = 1'b0;
    walk_step  = 1'b0;
    case (state_q)
      ST_IDLE: if (go) begin
        desc_d  = go_addr;
        state_d = ST_LOAD;
      end
      ST_LOAD: if (!halted) begin
        fidx_d  = '0;
        state_d = ST_FETCH;
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + {{(30-FIDX_W){1'b0}}, fidx_q, 2'b00};
        if (mem_ack) begin
          fld_we = 1'b1;
          if (fidx_q == LAST_FIELD) state_d = ST_PREP;
          else                      fidx_d  = fidx_q + 1'b1;
        end
      end
      ST_PREP: begin
        walk_init = 1'b1;
        state_d   = ST_NEXT;
      end
      ST_NEXT: if (!halted) begin
        if (walk_done)            state_d = ST_STAT;
        else if (cmd[CMD_DIR_BIT]) state_d = ST_MRD;
        else                      state_d = ST_GET;
      end
      ST_MRD: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          hold_d  = mem_rdata;
          state_d = ST_PUT;
        end
      end
      ST_PUT: begin
        pout_valid = 1'b1;
        if (pout_ready) begin
          walk_step = 1'b1;
          state_d   = ST_NEXT;
        end
      end
      ST_GET: begin
        pin_ready = 1'b1;
        if (pin_valid) begin
          hold_d  = pin_data;
          state_d = ST_MWR;
        end
      end
      ST_MWR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          walk_step = 1'b1;
          state_d   = ST_NEXT;
        end
      end
      ST_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_q + STAT_OFS;
        mem_wdata = STATUS_CODE;
        if (mem_ack) state_d = ST_FIN;
      end
      ST_FIN: begin
        irq_d = cmd[CMD_IRQ_BIT];
        if (nxt[NEXT_VALID_BIT]) begin
          desc_d  = {nxt[31:1], 1'b0};
          state_d = ST_LOAD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      fidx_q  <= '0;
      hold_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      desc_q  <= desc_d;
      fidx_q  <= fidx_d;
      hold_q  <= hold_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FETCH_WORDS; i++) fld_q[i] <= '0;
    end else if (fld_we) begin
      fld_q[fidx_q] <= mem_rdata;
    end
  end
endmodule

// File: rtl/lld_dma.sv
module lld_dma #(
  parameter logic [31:0] STATUS_CODE = 32'h1,
  parameter int unsigned CNT_W       = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic        busy,
  output logic [31:0] cur_desc,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic [31:0] periph_addr,
  output logic        pout_valid,
  output logic [31:0] pout_data,
  input  logic        pout_ready,
  input  logic        pin_valid,
  input  logic [31:0] pin_data,
  output logic        pin_ready,
  output logic        irq
);
  logic [1:0]  rst_pipe;
  logic        rst_sn;
  logic        go, halted, walk_init, walk_step, walk_done;
  logic [31:0] go_addr, walk_addr, f_mem, f_len, f_gap, f_blocks;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  lld_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sn), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .idle(!busy), .go(go), .go_addr(go_addr), .halted(halted)
  );

  lld_walker #(.CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_sn), .init(walk_init), .step(walk_step),
    .base(f_mem), .len(f_len[CNT_W-1:0]), .gap(f_gap[CNT_W-1:0]),
    .blocks(f_blocks[CNT_W-1:0]), .addr(walk_addr), .done(walk_done)
  );

  lld_seq #(.STATUS_CODE(STATUS_CODE)) u_seq (
    .clk(clk), .rst_n(rst_sn), .go(go), .go_addr(go_addr), .halted(halted),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pout_ready(pout_ready),
    .pin_valid(pin_valid), .pin_data(pin_data), .walk_addr(walk_addr),
    .walk_done(walk_done), .walk_init(walk_init), .walk_step(walk_step),
    .f_mem(f_mem), .f_len(f_len), .f_gap(f_gap), .f_blocks(f_blocks),
    .periph_addr(periph_addr), .busy(busy), .cur_desc(cur_desc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pout_valid(pout_valid), .pout_data(pout_data),
    .pin_ready(pin_ready), .irq(irq)
  );
endmodule

// File: rtl/lld_dma_chk.sv
module lld_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        pout_valid,
  input logic [31:0] pout_data,
  input logic        pout_ready,
  input logic        pin_ready,
  input logic        irq
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_pout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pout_valid && !pout_ready) |=> (pout_valid && $stable(pout_data)));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !pout_valid && !pin_ready));

  assert_one_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pout_valid && pin_ready));
endmodule

bind lld_dma lld_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .pout_valid(pout_valid), .pout_data(pout_data), .pout_ready(pout_ready),
  .pin_ready(pin_ready), .irq(irq)
);

// File: tb/sim_lld_dma.sv
module sim_lld_dma;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam int V_DIR [NV] = '{1, 1, 0, 0, 1, 0};
  localparam int V_LEN [NV] = '{4, 2, 3, 2, 1, 0};
  localparam int V_GAP [NV] = '{0, 2, 0, 1, 0, 0};
  localparam int V_CNT [NV] = '{1, 3, 2, 3, 4, 2};
  localparam int V_BASE[NV] = '{64, 80, 96, 128, 160, 176};
  localparam int V_IRQ [NV] = '{1, 1, 1, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic busy, mem_req, mem_we, pout_valid, pin_ready, irq;
  logic [31:0] cur_desc, mem_addr, mem_wdata, periph_addr, pout_data;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic pout_ready = 1'b0;
  logic pin_valid = 1'b0;
  logic [31:0] pin_data = '0;

  logic [31:0] mem  [256];
  logic [31:0] sink [128];
  int sink_n, src_n, irq_n, lat, lat_tgt, acks, cyc;
  int n_chk, n_bad;
  bit timed_out;

  lld_dma u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .busy(busy), .cur_desc(cur_desc), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .periph_addr(periph_addr), .pout_valid(pout_valid),
    .pout_data(pout_data), .pout_ready(pout_ready), .pin_valid(pin_valid),
    .pin_data(pin_data), .pin_ready(pin_ready), .irq(irq)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // memory and peripheral models, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mem_ack = 1'b0; lat = 0; pout_ready = 1'b0; pin_valid = 1'b0;
    end else begin
      if (mem_ack) begin
        mem_ack = 1'b0; lat = 0;
      end else if (mem_req) begin
        lat++;
        if (lat >= lat_tgt) begin
          mem_ack = 1'b1; acks++; lat_tgt = 1 + (acks % 3);
          if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[9:2]];
        end
      end
      pout_ready = (cyc % 3) != 1;
      if (pout_ready && pout_valid) begin sink[sink_n[6:0]] = pout_data; sink_n++; end
      pin_valid = (cyc % 4) != 2;
      pin_data  = 32'hA000_0000 + 32'(src_n);
      if (pin_valid && pin_ready) src_n++;
      if (irq) irq_n++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [31:0] w);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
    sink_n = 0; src_n = 0; irq_n = 0;
  endtask

  task automatic put_desc(input int at, input logic [31:0] nxt, input int base, input int len,
                          input int gap, input int cnt, input int dir, input int ien);
    mem[at]   = nxt;
    mem[at+1] = 32'(base * 4);
    mem[at+2] = 32'h9000 + 32'(at) + 32'(len);
    mem[at+3] = 32'(len);
    mem[at+4] = 32'(gap);
    mem[at+5] = 32'(cnt);
    mem[at+6] = (32'(dir) << 12) | (32'(ien) << 1);
    for (int k = 7; k < 12; k++) mem[at+k] = '0;
  endtask

  task automatic wait_idle(output bit seen, output logic [31:0] pa);
    seen = 1'b0; pa = '0; timed_out = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if ((pout_valid || pin_ready) && !seen) begin seen = 1'b1; pa = periph_addr; end
      if (!busy) break;
      if (t == 2999) timed_out = 1'b1;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bit seen, ok;
    logic [31:0] pa;
    int total, k, idx, held;
    lat_tgt = 1;
    do_reset();
    // R13: quiet after reset
    check(!busy && !irq && !mem_req && !pout_valid && !pin_ready, "R13 reset state",
          {27'd0, busy, irq, mem_req, pout_valid, pin_ready}, 32'd0);

    // table of single-descriptor vectors
    for (int v = 0; v < NV; v++) begin
      fill_mem();
      put_desc(0, 32'h0, V_BASE[v], V_LEN[v], V_GAP[v], V_CNT[v], V_DIR[v], V_IRQ[v]);
      ctl_write(32'h0000_0008);
      check(busy && cur_desc == 32'h0, "R1 start loads address", cur_desc, 32'h0);
      wait_idle(seen, pa);
      total = V_LEN[v] * V_CNT[v];
      check(!timed_out && !busy, "R9 chain end idles", {31'd0, busy}, 32'd0);
      if (V_DIR[v] == 1) check(sink_n == total, "R3 R6 word count out", 32'(sink_n), 32'(total));
      else               check(src_n == total, "R4 R6 word count in", 32'(src_n), 32'(total));
      ok = 1'b1; k = 0;
      for (int b = 0; b < V_CNT[v]; b++)
        for (int w = 0; w < V_LEN[v]; w++) begin
          idx = V_BASE[v] + b * (V_LEN[v] + V_GAP[v]) + w;
          if (V_DIR[v] == 1) begin
            if (sink[k] !== (32'hC0DE_0000 | 32'(idx))) ok = 1'b0;
          end else begin
            if (mem[idx] !== 32'hA000_0000 + 32'(k)) ok = 1'b0;
          end
          k++;
        end
      check(ok, "R5 R3 R4 R12 block data", 32'(v), 32'(v));
      if (V_GAP[v] > 0 && V_CNT[v] > 1) begin
        idx = V_BASE[v] + V_LEN[v];
        check(mem[idx] == (32'hC0DE_0000 | 32'(idx)), "R5 gap untouched", mem[idx], 32'hC0DE_0000 | 32'(idx));
      end
      check(mem[7] == 32'h1, "R7 status code", mem[7], 32'h1);
      check(irq_n == V_IRQ[v], "R8 R6 irq count", 32'(irq_n), 32'(V_IRQ[v]));
      if (seen) check(pa == 32'h9000 + 32'(V_LEN[v]), "R2 peripheral address", pa, 32'h9000 + 32'(V_LEN[v]));
    end

    // chain of two with mixed direction, irq only on the last
    fill_mem();
    put_desc(0,  32'h41, 64, 3, 0, 1, 1, 0);
    put_desc(16, 32'h0,  96, 2, 0, 1, 0, 1);
    ctl_write(32'h0000_0008);
    wait_idle(seen, pa);
    check(sink_n == 3 && sink[2] == (32'hC0DE_0000 | 32'd66), "R9 first link out", sink[2], 32'hC0DE_0042);
    check(mem[96] == 32'hA000_0000 && mem[97] == 32'hA000_0001, "R9 R4 second link in", mem[97], 32'hA000_0001);
    check(mem[7] == 32'h1 && mem[23] == 32'h1, "R7 both statuses", mem[23], 32'h1);
    check(irq_n == 1, "R8 irq only when bit set", 32'(irq_n), 32'd1);
    check(cur_desc == 32'h40, "R14 last descriptor address", cur_desc, 32'h40);

    // stop in mid-transfer, then resume
    fill_mem();
    put_desc(0, 32'h0, 64, 8, 0, 1, 1, 1);
    ctl_write(32'h0000_0008);
    for (int t = 0; t < 500 && sink_n < 3; t++) @(negedge clk);
    ctl_write(32'h0000_0010);
    repeat (10) @(negedge clk);
    held = sink_n;
    repeat (40) @(negedge clk);
    check(sink_n == held && busy && sink_n < 8, "R11 stop halts words", 32'(sink_n), 32'(held));
    ctl_write(32'h0000_0008);
    wait_idle(seen, pa);
    ok = (sink_n == 8);
    for (int i = 0; i < 8; i++) if (sink[i] !== (32'hC0DE_0000 | 32'(64 + i))) ok = 1'b0;
    check(ok, "R11 resume completes in order", 32'(sink_n), 32'd8);

    // cyclic chain
    fill_mem();
    put_desc(0,  32'h41, 64, 2, 0, 1, 1, 1);
    put_desc(16, 32'h01, 96, 2, 0, 1, 1, 1);
    ctl_write(32'h0000_0008);
    for (int t = 0; t < 3000 && irq_n < 5; t++) @(negedge clk);
    check(irq_n >= 5 && busy, "R10 cyclic keeps running", 32'(irq_n), 32'd5);
    check(sink[0] == 32'hC0DE_0040 && sink[2] == 32'hC0DE_0060 && sink[4] == 32'hC0DE_0040,
          "R10 wraps to first", sink[4], 32'hC0DE_0040);
    ctl_write(32'h0000_0010);
    repeat (20) @(negedge clk);
    check(busy, "R11 parked stays busy", {31'd0, busy}, 32'd1);
    do_reset();
    check(!busy && !mem_req && !irq, "R13 reset clears engine", {30'd0, busy, mem_req}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog all-requirements act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule